// File: doc/BRIEF.md
# Paged EEPROM Write-and-Poll Engine

This block is a bus master on the host side. It pushes a burst of bytes into a byte-wide paged EEPROM and then waits for the device's internal programming cycle to finish. The host first fills a 128-entry staging buffer. It then raises `start` with a base address, a byte count and a polling method. The engine issues one write strobe per byte, back to back. Every address it drives stays inside the 128-byte page selected by the upper address bits.

After the last strobe the engine releases the data bus and starts read cycles to detect completion. In data-compare mode it re-reads the last written location until bit 7 of the returned byte equals bit 7 of the byte it wrote. In toggle mode it compares bit 6 of each read with bit 6 of the read before it, and stops when two consecutive reads agree. A poll limit turns a device that never finishes into an error. All bus timing is counted in clock cycles.

The controller is a state machine with six states. IDLE waits for a request. STROBE_LO drives a strobe low. STROBE_HI is the recovery phase between strobes. READ holds an access. REST is a one-cycle pause between reads. FINISH pulses done. The transitions are:
- IDLE to STROBE_LO on an accepted start with a legal count.
- IDLE to FINISH on a start with an illegal count.
- STROBE_LO to STROBE_HI after the low time.
- STROBE_HI to STROBE_LO when more bytes remain.
- STROBE_HI to READ after the last byte.
- READ to FINISH on completion or when the poll limit is reached.
- READ to REST otherwise.
- REST to READ.
- FINISH to IDLE.

Top module: `eep_page_writer`

## Requirements
- R1: In reset and while idle, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high, and `mem_drive`, `busy` and `done` are low.
- R2: A start with a count N of 1 to 128 writes N bytes. Byte i comes from buffer entry i and goes to address {base[15:7], (base[6:0]+i) mod 128}, so the upper nine address bits never change during the request.
- R3: Each strobe holds `mem_we_n` low for exactly WE_LOW cycles with `mem_ce_n` low and `mem_oe_n` high. Successive falling edges of `mem_we_n` are exactly WE_LOW+WE_HIGH cycles apart.
- R4: `mem_drive` is low whenever `mem_oe_n` is low. Every poll read holds `mem_ce_n` and `mem_oe_n` low at the last written address.
- R5: With `poll_mode`=0 (data compare), reads repeat until bit 7 of the read byte equals bit 7 of the last byte written, and the read that matches ends polling.
- R6: With `poll_mode`=1 (toggle), bit 6 of each read is compared with bit 6 of the previous read of the same request. Polling ends on the first read that equals its predecessor, so at least two reads are made.
- R7: If MAX_POLLS reads pass without completion, polling stops after exactly MAX_POLLS reads and `err` is 1 with done. A completion on read MAX_POLLS or earlier gives `err`=0.
- R8: `busy` rises in the cycle after an accepted start and stays high through the single cycle in which `done` is high. It is low in the cycle after that.
- R9: A `start` raised while `busy` is high is ignored: no extra strobes, no second done pulse, and no change of the page being polled.
- R10: A start whose count is 0 or above 128 produces no strobe and no read. `done` and `err` go high in the cycle after the start.
- R11: `err` keeps its value after done until the next accepted start, which clears it for a legal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, sampled while idle |
| base_addr | input | 16 | First byte address; bits 15:7 select the page |
| byte_count | input | 8 | Number of bytes, legal range 1 to 128 |
| poll_mode | input | 1 | 0 = data compare on bit 7, 1 = toggle watch on bit 6 |
| buf_wr_en | input | 1 | Staging buffer write enable |
| buf_wr_idx | input | 7 | Staging buffer entry |
| buf_wr_data | input | 8 | Staging buffer data |
| mem_addr | output | 16 | Memory bus address |
| mem_dout | output | 8 | Memory bus write data, valid while `mem_drive` is high |
| mem_status | input | 2 | Bus data bits 7 and 6 returned by the memory during reads |
| mem_drive | output | 1 | Host drives the data bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Poll limit reached or illegal count |

## Verification
The vector walk drives data-compare and toggle requests against a device model whose busy period lasts a chosen number of reads. The request shapes include a single byte, a burst that wraps inside its page and a full 128-byte page. A busy period of zero tells apart an engine that checks the first read from one that always reads twice. Toggle cases with odd and even busy lengths and both starting phases tell apart comparing adjacent reads from comparing against a fixed value. Busy periods just inside and just beyond the poll limit separate an off-by-one limit from a correct one. Directed cases add a start while busy, counts of zero and 200, and error persistence.

// File: rtl/eep_pw_pkg.sv
package eep_pw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STROBE_LO,
        ST_STROBE_HI,
        ST_READ,
        ST_REST,
        ST_FINISH
    } eep_state_t;

    localparam int REST_CYCLES = 1;

endpackage

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int DEPTH = 128,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data
);

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_data;
        end
    end

    assign rd_data = store[rd_idx];

endmodule

// File: rtl/eep_phase_timer.sv
module eep_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] len,
    output logic          expire
);

    logic [TW-1:0] cnt_q;

    assign expire = run && (cnt_q == len - TW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

endmodule

// File: rtl/eep_poll_judge.sv
module eep_poll_judge (
    input  logic toggle_mode,
    input  logic rd_b7,
    input  logic rd_b6,
    input  logic saved_b7,
    input  logic prev_b6,
    input  logic have_prev,
    output logic finished
);

    always_comb begin
        if (toggle_mode) begin
            finished = have_prev && (rd_b6 == prev_b6);
        end else begin
            finished = (rd_b7 == saved_b7);
        end
    end

endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer
    import eep_pw_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int ADDR_W     = 16,
    parameter int WE_LOW     = 3,
    parameter int WE_HIGH    = 2,
    parameter int RD_ACC     = 2,
    parameter int MAX_POLLS  = 20,
    localparam int PG_W  = $clog2(PAGE_BYTES),
    localparam int CNT_W = PG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              poll_mode,
    input  logic              buf_wr_en,
    input  logic [PG_W-1:0]   buf_wr_idx,
    input  logic [7:0]        buf_wr_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_dout,
    input  logic [1:0]        mem_status,
    output logic              mem_drive,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              busy,
    output logic              done,
    output logic              err
);

    localparam int PAGE_W = ADDR_W - PG_W;
    localparam int PC_W   = $clog2(MAX_POLLS + 1);
    localparam int TW     = $clog2(WE_LOW + WE_HIGH + RD_ACC + REST_CYCLES + 1);

    eep_state_t state_q, state_d;

    logic [PAGE_W-1:0] page_q;
    logic [PG_W-1:0]   lo_q;
    logic [PG_W-1:0]   idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              mode_q;
    logic              saved_b7_q;
    logic              prev_b6_q;
    logic              have_prev_q;
    logic [PC_W-1:0]   polls_q;
    logic              err_q;

    logic          tmr_run;
    logic [TW-1:0] tmr_len;
    logic          tmr_expire;
    logic          poll_hit;
    logic          count_ok;
    logic          is_last;
    logic          poll_last;
    logic [7:0]    buf_rd;

    assign count_ok  = (byte_count != '0) && (byte_count <= CNT_W'(PAGE_BYTES));
    assign is_last   = ({1'b0, idx_q} == (cnt_q - CNT_W'(1)));
    assign poll_last = (polls_q == PC_W'(MAX_POLLS - 1));

    eep_page_buf #(.DEPTH(PAGE_BYTES)) u_buf (
        .clk     (clk),
        .wr_en   (buf_wr_en),
        .wr_idx  (buf_wr_idx),
        .wr_data (buf_wr_data),
        .rd_idx  (idx_q),
        .rd_data (buf_rd)
    );

    always_comb begin
        tmr_run = 1'b1;
        tmr_len = TW'(1);
        unique case (state_q)
            ST_STROBE_LO: tmr_len = TW'(WE_LOW);
            ST_STROBE_HI: tmr_len = TW'(WE_HIGH);
            ST_READ:      tmr_len = TW'(RD_ACC);
            ST_REST:      tmr_len = TW'(REST_CYCLES);
            default:      tmr_run = 1'b0;
        endcase
    end

    eep_phase_timer #(.TW(TW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .len    (tmr_len),
        .expire (tmr_expire)
    );

    eep_poll_judge u_judge (
        .toggle_mode (mode_q),
        .rd_b7       (mem_status[1]),
        .rd_b6       (mem_status[0]),
        .saved_b7    (saved_b7_q),
        .prev_b6     (prev_b6_q),
        .have_prev   (have_prev_q),
        .finished    (poll_hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = count_ok ? ST_STROBE_LO : ST_FINISH;
            ST_STROBE_LO: if (tmr_expire) state_d = ST_STROBE_HI;
            ST_STROBE_HI: if (tmr_expire) state_d = is_last ? ST_READ : ST_STROBE_LO;
            ST_READ:      if (tmr_expire) state_d = (poll_hit || poll_last) ? ST_FINISH : ST_REST;
            ST_REST:      if (tmr_expire) state_d = ST_READ;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request context and poll bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q      <= '0;
            lo_q        <= '0;
            idx_q       <= '0;
            cnt_q       <= '0;
            mode_q      <= 1'b0;
            saved_b7_q  <= 1'b0;
            prev_b6_q   <= 1'b0;
            have_prev_q <= 1'b0;
            polls_q     <= '0;
            err_q       <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        page_q      <= base_addr[ADDR_W-1:PG_W];
                        lo_q        <= base_addr[PG_W-1:0];
                        cnt_q       <= byte_count;
                        mode_q      <= poll_mode;
                        idx_q       <= '0;
                        polls_q     <= '0;
                        have_prev_q <= 1'b0;
                        err_q       <= !count_ok;
                    end
                end
                ST_STROBE_HI: begin
                    saved_b7_q <= buf_rd[7];
                    if (tmr_expire && !is_last) begin
                        idx_q <= idx_q + PG_W'(1);
                    end
                end
                ST_READ: begin
                    if (tmr_expire && !poll_hit) begin
                        prev_b6_q   <= mem_status[0];
                        have_prev_q <= 1'b1;
                        polls_q     <= polls_q + PC_W'(1);
                        if (poll_last) begin
                            err_q <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // bus and status outputs
    always_comb begin
        mem_addr  = {page_q, lo_q + idx_q};
        mem_dout  = buf_rd;
        mem_drive = 1'b0;
        mem_ce_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        busy      = (state_q != ST_IDLE);
        done      = 1'b0;
        err       = err_q;
        unique case (state_q)
            ST_STROBE_LO: begin
                mem_drive = 1'b1;
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
            end
            ST_STROBE_HI: begin
                mem_drive = 1'b1;
                mem_ce_n  = 1'b0;
            end
            ST_READ: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/eep_page_writer_chk.sv
module eep_page_writer_chk #(
    parameter int ADDR_W  = 16,
    parameter int PG_W    = 7,
    parameter int WE_LOW  = 3,
    parameter int WE_HIGH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_drive,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              busy,
    input logic              done
);

    logic [15:0] lo_run;
    logic [15:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_run <= '0;
            hi_run <= '0;
        end else begin
            lo_run <= !mem_we_n ? lo_run + 16'd1 : 16'd0;
            hi_run <= (mem_drive && mem_we_n) ? hi_run + 16'd1 : 16'd0;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_drive));

    assert_page_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:PG_W]));

    assert_strobe_ctl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    assert_strobe_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (lo_run == 16'(WE_LOW)));

    assert_strobe_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_we_n) && $past(mem_drive)) |-> (hi_run == 16'(WE_HIGH)));

    assert_bus_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_drive);

    assert_done_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

bind eep_page_writer eep_page_writer_chk #(
    .ADDR_W  (ADDR_W),
    .PG_W    (PG_W),
    .WE_LOW  (WE_LOW),
    .WE_HIGH (WE_HIGH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_drive (mem_drive),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_eep_page_writer.sv
`timescale 1ns/1ps
module sim_eep_page_writer;

    localparam int WEL  = 3;
    localparam int WEH  = 2;
    localparam int RDA  = 2;
    localparam int MAXP = 20;
    localparam int NV   = 9;

    // {mode, toggle start phase, base, count, busy reads}
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 1'b0, 16'h1200, 8'd1,   8'd3},
        {1'b0, 1'b0, 16'h3479, 8'd10,  8'd0},
        {1'b0, 1'b0, 16'hFF80, 8'd128, 8'd5},
        {1'b1, 1'b0, 16'h0040, 8'd4,   8'd4},
        {1'b1, 1'b1, 16'h7A7F, 8'd3,   8'd0},
        {1'b1, 1'b1, 16'h0101, 8'd2,   8'd1},
        {1'b0, 1'b0, 16'h2222, 8'd6,   8'd19},
        {1'b1, 1'b0, 16'h5555, 8'd5,   8'd19},
        {1'b0, 1'b0, 16'h4000, 8'd7,   8'd30}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] base_addr = '0;
    logic [7:0]  byte_count = '0;
    logic        poll_mode = 1'b0;
    logic        buf_wr_en = 1'b0;
    logic [6:0]  buf_wr_idx = '0;
    logic [7:0]  buf_wr_data = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_dout;
    logic [7:0]  din = '0;
    logic        mem_drive, mem_ce_n, mem_we_n, mem_oe_n, busy, done, err;

    always #4 clk = ~clk;

    eep_page_writer #(.WE_LOW(WEL), .WE_HIGH(WEH), .RD_ACC(RDA), .MAX_POLLS(MAXP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .byte_count(byte_count), .poll_mode(poll_mode), .buf_wr_en(buf_wr_en),
        .buf_wr_idx(buf_wr_idx), .buf_wr_data(buf_wr_data), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_status(din[7:6]), .mem_drive(mem_drive),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .busy(busy), .done(done), .err(err)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // device model state
    int          nstrobes, nreads, ndone, reads_left, cfg_busy;
    bit          cfg_t0, tog, timing_bad, bus_bad, rdaddr_bad;
    logic [15:0] log_addr [128];
    logic [7:0]  log_data [128];
    logic [15:0] last_addr;
    logic [7:0]  last_data;
    time         fall_t, prev_fall_t;

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            chk(1'b0, "watchdog", cyc, 0);
            report();
            $finish;
        end
    end

    always @(negedge mem_we_n) if (rst_n) begin
        if (nstrobes > 0 && ($time - prev_fall_t) != (WEL + WEH) * 8) timing_bad = 1'b1;
        prev_fall_t = $time;
        fall_t = $time;
    end

    always @(posedge mem_we_n) if (rst_n) begin
        if (($time - fall_t) != WEL * 8) timing_bad = 1'b1;
        if (nstrobes < 128) begin
            log_addr[nstrobes] = mem_addr;
            log_data[nstrobes] = mem_dout;
        end
        nstrobes++;
        last_addr = mem_addr;
        last_data = mem_dout;
        reads_left = cfg_busy;
        tog = cfg_t0;
    end

    always @(negedge mem_oe_n) if (rst_n) begin
        nreads++;
        if (mem_addr != last_addr) rdaddr_bad = 1'b1;
        if (reads_left > 0) begin
            reads_left--;
            din = {~last_data[7], tog, last_data[5:0]};
            tog = ~tog;
        end else begin
            din = last_data;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !mem_oe_n && mem_drive) bus_bad = 1'b1;
        if (rst_n && done) ndone++;
    end

    function automatic logic [7:0] bdat(input int v, input int i);
        return 8'((i * 29 + v * 53 + 17) ^ 8'h5A);
    endfunction

    function automatic int toggle_reads(input int b, input bit t0, input bit tr);
        bit prev = 1'b0;
        bit cur;
        for (int k = 1; k <= b + 2; k++) begin
            cur = (k <= b) ? (t0 ^ bit'((k - 1) % 2)) : tr;
            if (k >= 2 && cur == prev) return k;
            prev = cur;
        end
        return b + 2;
    endfunction

    task automatic clear_model(input int busy_reads, input bit t0);
        nstrobes = 0; nreads = 0; ndone = 0;
        timing_bad = 0; bus_bad = 0; rdaddr_bad = 0;
        cfg_busy = busy_reads; cfg_t0 = t0;
    endtask

    task automatic load_buf(input int v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            buf_wr_en = 1'b1; buf_wr_idx = 7'(i); buf_wr_data = bdat(v, i);
        end
        @(negedge clk);
        buf_wr_en = 1'b0;
    endtask

    task automatic fire(input logic [15:0] b, input logic [7:0] n, input bit m);
        @(negedge clk);
        base_addr = b; byte_count = n; poll_mode = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (ndone == 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_drive && !busy && !done,
            "R1 bus idle in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_drive, busy, done}, 6'b111000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_drive && !busy && !done,
            "R1 bus idle after reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_drive, busy, done}, 6'b111000);

        for (int v = 0; v < NV; v++) begin
            bit          m   = VEC[v][33];
            bit          t0  = VEC[v][32];
            logic [15:0] b   = VEC[v][31:16];
            int          n   = int'(VEC[v][15:8]);
            int          bz  = int'(VEC[v][7:0]);
            int          exp_rd;
            bit          exp_err;
            bit          addr_ok = 1'b1;
            load_buf(v, n);
            clear_model(bz, t0);
            exp_rd = m ? toggle_reads(bz, t0, bdat(v, n - 1)[6]) : bz + 1;
            exp_err = exp_rd > MAXP;
            if (exp_err) exp_rd = MAXP;
            fire(b, 8'(n), m);
            wait_done();
            for (int i = 0; i < n && i < 128; i++) begin
                if (log_addr[i] != {b[15:7], 7'(b[6:0] + 7'(i))} || log_data[i] != bdat(v, i))
                    addr_ok = 1'b0;
            end
            chk(nstrobes == n, "R2 strobe count", nstrobes, n);
            chk(addr_ok, "R2 address and data per byte", addr_ok, 1);
            chk(!timing_bad, "R3 strobe low time and spacing", timing_bad, 0);
            chk(!bus_bad && !rdaddr_bad, "R4 bus released, read at last address",
                {bus_bad, rdaddr_bad}, 0);
            chk(nreads == exp_rd, m ? "R6 toggle read count" : "R5 data poll read count",
                nreads, exp_rd);
            chk(err == exp_err, "R7 error flag", err, exp_err);
            chk(ndone == 1 && !busy, "R8 single done then idle", ndone, 1);
        end

        // R9: start while busy is ignored
        load_buf(20, 4);
        clear_model(6, 1'b0);
        fire(16'h6100, 8'd4, 1'b0);
        while (nreads == 0) @(negedge clk);
        base_addr = 16'h0000; byte_count = 8'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(nstrobes == 4 && ndone == 1, "R9 start while busy ignored", nstrobes, 4);
        chk(last_addr[15:7] == 9'(16'h6100 >> 7), "R9 polled page unchanged", last_addr[15:7], 9'(16'h6100 >> 7));

        // R10: illegal counts
        clear_model(0, 1'b0);
        @(negedge clk);
        base_addr = 16'h0800; byte_count = 8'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && busy && err, "R10 count 0 finishes next cycle with err", {done, busy, err}, 3'b111);
        wait_done();
        chk(nstrobes == 0 && nreads == 0, "R10 count 0 makes no bus cycles", nstrobes + nreads, 0);
        clear_model(0, 1'b0);
        fire(16'h0800, 8'd200, 1'b1);
        wait_done();
        chk(nstrobes == 0 && nreads == 0 && err, "R10 count 200 rejected", nstrobes + nreads, 0);

        // R11: err persists, then clears on an accepted start
        repeat (5) @(negedge clk);
        chk(err == 1'b1, "R11 err held while idle", err, 1);
        load_buf(21, 2);
        clear_model(0, 1'b0);
        @(negedge clk);
        base_addr = 16'h1000; byte_count = 8'd2; poll_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b0 && busy, "R11 err cleared by accepted start, R8 busy", {err, busy}, 2'b01);
        wait_done();
        chk(!err && nstrobes == 2, "R11 clean finish", err, 0);

        report();
        $finish;
    end

endmodule